// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects clocked logic to an external asynchronous static RAM that holds 256K bytes. On the user side there is a request/acknowledge port. The requester raises `req` together with the address, the write data and a write flag, and holds them until `ack` pulses. For a read, `rd_data` returns the captured byte. On the memory side the block drives an 18-bit address and two chip enables of opposite polarity: `mem_ce1_n` is active low and `mem_ce2` is active high. It also drives an active-low output enable and an active-low write enable. The data bus is split into `mem_dq_out`, `mem_dq_in` and `mem_dq_oe`, so the pad ring can build the tri-state buffer.

The length of each phase is a whole number of clock cycles. That number comes from nanosecond limits divided by the clock period `CLK_NS` and rounded up, with a floor of one cycle. `GRADE` picks one of two timing sets: 0 is the faster part and 1 is the slower part. A write is a sequence of four phases:
- a select cycle with every strobe quiet;
- a write-enable pulse while the block drives the bus;
- a hold cycle after the strobe rises;
- a deselected acknowledge cycle.

A read holds chip select and output enable for the access time, samples the bus on the last access cycle, and then deselects. It then keeps the bus quiet long enough for the memory to stop driving.

Top module: `sram_bridge`

## Requirements
- R1: After reset and whenever no access is in progress, the memory pins show the deselected pattern: `mem_ce1_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0. An asynchronous low on `rst_n` forces this pattern at once.
- R2: A read selects the chip, pulls `mem_oe_n` low and keeps `mem_we_n` high and `mem_dq_oe` low for a fixed number of cycles. The count is 3 at `CLK_NS`=20 with `GRADE`=0 and 4 with `GRADE`=1. The phase starts at the edge that accepts the request.
- R3: On the last read cycle, `mem_dq_in` is sampled into `rd_data`. `rd_data` holds that value until the next read completes. `ack` is high in the following cycle, by which time the chip is already deselected.
- R4: A write first spends one cycle with the chip selected and both `mem_we_n` and `mem_oe_n` high. It then holds `mem_we_n` low for 2 cycles (`GRADE`=0) or 3 cycles (`GRADE`=1). `mem_oe_n` stays high for the whole write.
- R5: `mem_dq_oe` is high exactly while `mem_we_n` is low, and during that time `mem_dq_out` carries the accepted write byte. The bus is released at the same edge at which `mem_we_n` rises.
- R6: After `mem_we_n` rises, the chip stays selected and the address stays unchanged for one more cycle. `ack` then pulses with the chip deselected.
- R7: After `mem_oe_n` rises, `mem_dq_oe` stays low for at least 2 cycles at the defaults.
- R8: A request is taken only when the block is idle. Address, data and the write flag are captured at that edge, so later changes to them do not affect the access in progress.
- R9: `ack` lasts one cycle. Between any two accesses the chip spends at least one cycle deselected.
- R10: The end-to-end latency, counted from the accepting edge to the edge that raises `ack`, is 3 cycles for a read and 4 for a write with `GRADE`=0. With `GRADE`=1 it is 4 cycles for a read and 5 for a write.
- R11: `mem_addr` equals the accepted address and does not change while the chip is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period `CLK_NS` ns |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until `ack` |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write byte |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| mem_addr | output | 18 | Memory address |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_in | input | 8 | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |

## Verification
The latency of each result is counted in falling-edge samples after the request is raised. With the defaults, the first read-phase pins are visible at sample 1 and a read's `ack` and `rd_data` at sample 4. A write's low `mem_we_n` is visible at samples 2 and 3, its hold cycle at sample 4 and its `ack` at sample 5. The slow-grade instance reports `ack` one sample later for both kinds of access. Each timing check waits for the bridge to go idle first, so that the count starts at the accepting edge, and it samples on the falling clock edge after that many rising edges.

// File: rtl/sram_bridge_pkg.sv
`timescale 1ns/1ps
package sram_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RD_REST,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_END,
        ST_DONE
    } state_e;

    // Nanosecond limits of one speed grade.
    typedef struct packed {
        int unsigned rd_cycle;
        int unsigned addr_acc;
        int unsigned oe_acc;
        int unsigned oe_float;
        int unsigned wr_cycle;
        int unsigned sel_to_end;
        int unsigned addr_to_end;
        int unsigned we_width;
        int unsigned data_setup;
    } ns_set_t;

    function automatic ns_set_t grade_ns(input int unsigned grade);
        ns_set_t s;
        if (grade == 0) begin
            s.rd_cycle    = 55;
            s.addr_acc    = 55;
            s.oe_acc      = 25;
            s.oe_float    = 20;
            s.wr_cycle    = 55;
            s.sel_to_end  = 45;
            s.addr_to_end = 45;
            s.we_width    = 40;
            s.data_setup  = 25;
        end else begin
            s.rd_cycle    = 70;
            s.addr_acc    = 70;
            s.oe_acc      = 35;
            s.oe_float    = 25;
            s.wr_cycle    = 70;
            s.sel_to_end  = 60;
            s.addr_to_end = 60;
            s.we_width    = 50;
            s.data_setup  = 30;
        end
        return s;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Rounds up to whole clock cycles; never less than one.
    function automatic int unsigned to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned rd_cycles(input int unsigned grade, input int unsigned clk_ns);
        ns_set_t s;
        s = grade_ns(grade);
        return max2(max2(to_cyc(s.addr_acc, clk_ns), to_cyc(s.oe_acc, clk_ns)),
                    to_cyc(s.rd_cycle, clk_ns));
    endfunction

    // Float time of the memory plus one full spare cycle.
    function automatic int unsigned rest_cycles(input int unsigned grade, input int unsigned clk_ns);
        ns_set_t s;
        s = grade_ns(grade);
        return to_cyc(s.oe_float, clk_ns) + 1;
    endfunction

    // The select cycle before the pulse counts toward select/address-to-end.
    function automatic int unsigned pulse_cycles(input int unsigned grade, input int unsigned clk_ns);
        ns_set_t s;
        s = grade_ns(grade);
        return max2(max2(to_cyc(s.we_width, clk_ns), to_cyc(s.data_setup, clk_ns)),
                    max2(to_cyc(s.addr_to_end, clk_ns) - 1, to_cyc(s.sel_to_end, clk_ns) - 1));
    endfunction

    function automatic int unsigned end_cycles(input int unsigned grade, input int unsigned clk_ns);
        ns_set_t     s;
        int unsigned used;
        int unsigned need;
        s    = grade_ns(grade);
        used = 1 + pulse_cycles(grade, clk_ns);
        need = to_cyc(s.wr_cycle, clk_ns);
        return (need > used + 1) ? (need - used) : 1;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = len - CW'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_bridge_fsm.sv
`timescale 1ns/1ps
module sram_bridge_fsm
    import sram_bridge_pkg::*;
#(
    parameter int unsigned AW       = 18,
    parameter int unsigned DW       = 8,
    parameter int unsigned CW       = 4,
    parameter int unsigned RD_LEN   = 3,
    parameter int unsigned REST_LEN = 2,
    parameter int unsigned PUL_LEN  = 2,
    parameter int unsigned END_LEN  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_dq_in,
    input  logic          tmr_last,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_len,
    output logic          ack,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] addr,
    output logic          sel,
    output logic          oe,
    output logic          we,
    output logic          drive,
    output logic [DW-1:0] wdata
);
    typedef struct packed {
        state_e        state;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          sel;
        logic          oe;
        logic          we;
        logic          drive;
        logic          ack;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        state: ST_IDLE, addr: '0, wdata: '0, rdata: '0,
        sel: 1'b0, oe: 1'b0, we: 1'b0, drive: 1'b0, ack: 1'b0
    };

    regs_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        tmr_load = 1'b0;
        tmr_len  = '0;
        case (st_q.state)
            ST_IDLE: begin
                if (req) begin
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                    st_d.sel   = 1'b1;
                    if (req_wr) begin
                        st_d.state = ST_WR_SETUP;
                    end else begin
                        st_d.state = ST_RD;
                        st_d.oe    = 1'b1;
                        tmr_load   = 1'b1;
                        tmr_len    = CW'(RD_LEN);
                    end
                end
            end
            ST_RD: begin
                if (tmr_last) begin
                    st_d.rdata = mem_dq_in;
                    st_d.sel   = 1'b0;
                    st_d.oe    = 1'b0;
                    st_d.ack   = 1'b1;
                    st_d.state = ST_RD_REST;
                    tmr_load   = 1'b1;
                    tmr_len    = CW'(REST_LEN);
                end
            end
            ST_RD_REST: begin
                if (tmr_last) begin
                    st_d.state = ST_IDLE;
                end
            end
            ST_WR_SETUP: begin
                st_d.we    = 1'b1;
                st_d.drive = 1'b1;
                st_d.state = ST_WR_PULSE;
                tmr_load   = 1'b1;
                tmr_len    = CW'(PUL_LEN);
            end
            ST_WR_PULSE: begin
                if (tmr_last) begin
                    st_d.we    = 1'b0;
                    st_d.drive = 1'b0;
                    st_d.state = ST_WR_END;
                    tmr_load   = 1'b1;
                    tmr_len    = CW'(END_LEN);
                end
            end
            ST_WR_END: begin
                if (tmr_last) begin
                    st_d.sel   = 1'b0;
                    st_d.ack   = 1'b1;
                    st_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                st_d.state = ST_IDLE;
            end
            default: begin
                st_d = RESET_VAL;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack     = st_q.ack;
    assign rd_data = st_q.rdata;
    assign addr    = st_q.addr;
    assign sel     = st_q.sel;
    assign oe      = st_q.oe;
    assign we      = st_q.we;
    assign drive   = st_q.drive;
    assign wdata   = st_q.wdata;
endmodule

// File: rtl/sram_bridge.sv
`timescale 1ns/1ps
module sram_bridge #(
    parameter int unsigned CLK_NS = 20,
    parameter int unsigned GRADE  = 0,
    parameter int unsigned AW     = 18,
    parameter int unsigned DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ack,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce1_n,
    output logic          mem_ce2,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    input  logic [DW-1:0] mem_dq_in,
    output logic          mem_dq_oe
);
    localparam int unsigned RD_LEN   = sram_bridge_pkg::rd_cycles(GRADE, CLK_NS);
    localparam int unsigned REST_LEN = sram_bridge_pkg::rest_cycles(GRADE, CLK_NS);
    localparam int unsigned PUL_LEN  = sram_bridge_pkg::pulse_cycles(GRADE, CLK_NS);
    localparam int unsigned END_LEN  = sram_bridge_pkg::end_cycles(GRADE, CLK_NS);
    localparam int unsigned LEN_MAX  = sram_bridge_pkg::max2(
                                           sram_bridge_pkg::max2(RD_LEN, REST_LEN),
                                           sram_bridge_pkg::max2(PUL_LEN, END_LEN));
    localparam int unsigned CW       = $clog2(LEN_MAX + 1);

    logic          tmr_load;
    logic [CW-1:0] tmr_len;
    logic          tmr_last;
    logic          sel, oe, we, drive;

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .last  (tmr_last)
    );

    sram_bridge_fsm #(
        .AW(AW), .DW(DW), .CW(CW),
        .RD_LEN(RD_LEN), .REST_LEN(REST_LEN), .PUL_LEN(PUL_LEN), .END_LEN(END_LEN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_in (mem_dq_in),
        .tmr_last  (tmr_last),
        .tmr_load  (tmr_load),
        .tmr_len   (tmr_len),
        .ack       (ack),
        .rd_data   (rd_data),
        .addr      (mem_addr),
        .sel       (sel),
        .oe        (oe),
        .we        (we),
        .drive     (drive),
        .wdata     (mem_dq_out)
    );

    // One select register feeds both enables, so they can never disagree.
    assign mem_ce1_n = ~sel;
    assign mem_ce2   = sel;
    assign mem_oe_n  = ~oe;
    assign mem_we_n  = ~we;
    assign mem_dq_oe = drive;
endmodule

// File: rtl/sram_bridge_chk.sv
`timescale 1ns/1ps
module sram_bridge_chk #(
    parameter int unsigned CLK_NS = 20,
    parameter int unsigned GRADE  = 0,
    parameter int unsigned AW     = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce1_n,
    input logic          mem_ce2,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_dq_oe
);
    localparam logic [7:0] HZ = 8'(sram_bridge_pkg::rest_cycles(GRADE, CLK_NS));

    // Cycles since output enable was last active; saturates.
    logic [7:0] oe_off_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_off_q <= 8'hFF;
        end else if (!mem_oe_n) begin
            oe_off_q <= 8'h00;
        end else if (oe_off_q != 8'hFF) begin
            oe_off_q <= oe_off_q + 8'h01;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce2 |-> (mem_ce1_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    p_read_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_dq_oe && mem_ce2));

    p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_write_oe_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce1_n && mem_ce2));

    p_select_before_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(mem_ce2));

    p_drive_only_in_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);

    p_release_with_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_dq_oe);

    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_ce2 && $stable(mem_addr)));

    p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_off_q >= HZ));

    p_deselect_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce2) |=> !mem_ce2);

    p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ce2 && $past(mem_ce2)) |-> $stable(mem_addr));
endmodule

bind sram_bridge sram_bridge_chk #(.CLK_NS(CLK_NS), .GRADE(GRADE), .AW(AW)) u_chk (.*);

// File: tb/sram_bridge_test.sv
`timescale 1ns/1ps
module sram_bridge_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, req, req_wr, ack, ce1_n, ce2, oe_n, we_n, dq_oe;
    logic [17:0] req_addr, maddr;
    logic [7:0]  req_wdata, rd_data, dq_out, dq_in;

    logic        s_req, s_wr, s_ack, s_ce1_n, s_ce2, s_oe_n, s_we_n, s_dq_oe;
    logic [17:0] s_maddr;
    logic [7:0]  s_rd, s_dq_out;

    sram_bridge uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data), .mem_addr(maddr),
        .mem_ce1_n(ce1_n), .mem_ce2(ce2), .mem_oe_n(oe_n), .mem_we_n(we_n),
        .mem_dq_out(dq_out), .mem_dq_in(dq_in), .mem_dq_oe(dq_oe)
    );

    sram_bridge #(.GRADE(1)) uut_slow (
        .clk(clk), .rst_n(rst_n), .req(s_req), .req_wr(s_wr), .req_addr(18'h00042),
        .req_wdata(8'h99), .ack(s_ack), .rd_data(s_rd), .mem_addr(s_maddr),
        .mem_ce1_n(s_ce1_n), .mem_ce2(s_ce2), .mem_oe_n(s_oe_n), .mem_we_n(s_we_n),
        .mem_dq_out(s_dq_out), .mem_dq_in(8'h3C), .mem_dq_oe(s_dq_oe)
    );

    // Memory model: 64 tagged slots; a wrong address reads back 8'hEE.
    logic [7:0]  m_data [64];
    logic [17:0] m_tag  [64];
    function automatic int slot(input logic [17:0] a);
        return int'((a[5:0] + a[17:12]) & 6'h3F);
    endfunction
    assign dq_in = (!ce1_n && ce2 && !oe_n && we_n && m_tag[slot(maddr)] == maddr)
                   ? m_data[slot(maddr)] : 8'hEE;

    int ce_low_run = 0, min_gap = 1000, oe_gap = 0, last_gap = -1, s_we_cnt = 0;
    logic dq_prev = 1'b0;
    always @(negedge clk) begin
        if (!ce1_n && ce2 && !we_n && dq_oe) begin
            m_data[slot(maddr)] = dq_out;
            m_tag[slot(maddr)]  = maddr;
        end
        if (!ce2) ce_low_run++;
        else begin
            if (ce_low_run > 0 && ce_low_run < min_gap) min_gap = ce_low_run;
            ce_low_run = 0;
        end
        if (!oe_n) oe_gap = 0;
        else if (!dq_oe) oe_gap++;
        if (dq_oe && !dq_prev) last_gap = oe_gap;
        dq_prev = dq_oe;
        if (!s_we_n) s_we_cnt++;
    end

    int checks = 0, fails = 0;
    bit reported = 0;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  test done: total=%0d bad=%0d", checks, fails);
        end
    endtask

    task automatic access(input bit wr, input logic [17:0] a, input logic [7:0] d, output int lat);
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!ack && lat < 50);
        req = 1'b0;
    endtask

    typedef struct packed {
        logic        wr;
        logic [17:0] addr;
        logic [7:0]  data;
    } vec_t;

    localparam vec_t VECS [13] = '{
        '{1'b1, 18'h00000, 8'hA5}, '{1'b1, 18'h3FFFF, 8'h5A}, '{1'b1, 18'h12345, 8'hC3},
        '{1'b0, 18'h00000, 8'hA5}, '{1'b0, 18'h3FFFF, 8'h5A}, '{1'b1, 18'h2AAAA, 8'h00},
        '{1'b1, 18'h15555, 8'hFF}, '{1'b0, 18'h12345, 8'hC3}, '{1'b0, 18'h2AAAA, 8'h00},
        '{1'b0, 18'h15555, 8'hFF}, '{1'b1, 18'h00000, 8'h81}, '{1'b0, 18'h00000, 8'h81},
        '{1'b0, 18'h3FFFF, 8'h5A}
    };

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        report();
        $finish;
    end

    initial begin
        int lat;
        for (int i = 0; i < 64; i++) begin
            m_data[i] = 8'h00;
            m_tag[i]  = 18'h3FFFF ^ 18'(i);
        end
        rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
        s_req = 1'b0; s_wr = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset pattern
        check(ce1_n && !ce2 && oe_n && we_n && !dq_oe && !ack, "R1 reset pattern",
              {ce1_n, ce2, oe_n, we_n, dq_oe, ack}, 6'b101100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(ce1_n && !ce2 && oe_n && we_n && !dq_oe, "R1 idle pattern",
              {ce1_n, ce2, oe_n, we_n, dq_oe}, 5'b10110);

        // Vector table walk (R3 data, R11 address via tag)
        for (int i = 0; i < 13; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].data, lat);
            if (!VECS[i].wr)
                check(rd_data == VECS[i].data, "R3/R11 read back", rd_data, VECS[i].data);
        end

        // Cycle-exact read phase (R2, R3, R10)
        repeat (4) @(negedge clk);
        req = 1'b1; req_wr = 1'b0; req_addr = 18'h00000;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            check(ce2 && !ce1_n && !oe_n && we_n && !dq_oe && !ack, "R2 read strobes",
                  {ce2, oe_n, we_n, dq_oe, ack}, 5'b10100);
        end
        @(negedge clk);
        check(ack && rd_data == 8'h81, "R3 ack with data", {ack, rd_data}, {1'b1, 8'h81});
        check(!ce2 && oe_n, "R3 deselected at ack", {ce2, oe_n}, 2'b01);
        req = 1'b0;
        @(negedge clk);
        check(!ack, "R9 ack single cycle", ack, 0);

        // Cycle-exact write phase (R4, R5, R6, R8)
        repeat (4) @(negedge clk);
        req = 1'b1; req_wr = 1'b1; req_addr = 18'h00001; req_wdata = 8'h3C;
        @(negedge clk);
        check(ce2 && we_n && oe_n && !dq_oe, "R4 select cycle", {ce2, we_n, oe_n, dq_oe}, 4'b1110);
        req_wdata = 8'hFF; req_addr = 18'h00002; req_wr = 1'b0;
        for (int k = 2; k <= 3; k++) begin
            @(negedge clk);
            check(!we_n && oe_n && ce2, "R4 write pulse", {we_n, oe_n, ce2}, 3'b011);
            check(dq_oe && dq_out == 8'h3C, "R5 drive data", {dq_oe, dq_out}, {1'b1, 8'h3C});
        end
        @(negedge clk);
        check(we_n && !dq_oe && ce2 && maddr == 18'h00001, "R6 hold cycle",
              {we_n, dq_oe, ce2}, 3'b101);
        @(negedge clk);
        check(ack && !ce2, "R6 ack deselected", {ack, ce2}, 2'b10);
        req = 1'b0;
        access(1'b0, 18'h00001, 8'h00, lat);
        check(rd_data == 8'h3C, "R8 changes after accept ignored", rd_data, 8'h3C);

        // Latency at defaults (R10)
        repeat (4) @(negedge clk);
        access(1'b0, 18'h12345, 8'h00, lat);
        check(lat == 4, "R10 read latency", lat, 4);
        repeat (4) @(negedge clk);
        access(1'b1, 18'h00003, 8'h77, lat);
        check(lat == 5, "R10 write latency", lat, 5);

        // Turnaround and gap (R7, R9): read then write back to back
        access(1'b0, 18'h00003, 8'h00, lat);
        check(rd_data == 8'h77, "R3 read after write", rd_data, 8'h77);
        access(1'b1, 18'h00004, 8'h11, lat);
        check(last_gap >= 2, "R7 bus turnaround", last_gap, 2);
        check(min_gap >= 1, "R9 deselect gap", min_gap, 1);

        // Slow grade (R10, R4)
        repeat (4) @(negedge clk);
        s_req = 1'b1; s_wr = 1'b0; lat = 0;
        do begin @(negedge clk); lat++; end while (!s_ack && lat < 50);
        s_req = 1'b0;
        check(lat == 5 && s_rd == 8'h3C, "R10 slow read", {lat[7:0], s_rd}, {8'd5, 8'h3C});
        repeat (4) @(negedge clk);
        s_we_cnt = 0;
        s_req = 1'b1; s_wr = 1'b1; lat = 0;
        do begin @(negedge clk); lat++; end while (!s_ack && lat < 50);
        s_req = 1'b0;
        check(lat == 6, "R10 slow write latency", lat, 6);
        check(s_we_cnt == 3, "R4 slow pulse width", s_we_cnt, 3);

        // Reset in the middle of a write pulse (R1)
        repeat (4) @(negedge clk);
        req = 1'b1; req_wr = 1'b1; req_addr = 18'h00005; req_wdata = 8'h55;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(ce1_n && !ce2 && oe_n && we_n && !dq_oe, "R1 async reset mid write",
              {ce1_n, ce2, oe_n, we_n, dq_oe}, 5'b10110);
        req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(ce1_n && !ce2 && !ack, "R1 idle after reset", {ce1_n, ce2, ack}, 3'b100);

        report();
        $finish;
    end
endmodule